// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external asynchronous static RAM with 19 address bits and 8 data bits. The host issues single-byte reads and writes over a valid/ready request channel. The controller then sequences the active-low chip select, output enable and write enable strobes so that every nanosecond minimum of the chosen memory speed grade is met. The write and read phase lengths are whole clock cycles. Each is the ceiling of its nanosecond minimum divided by the `CLK_NS` parameter, with a floor of one cycle. `SLOW_GRADE` selects between the 55 ns grade (0) and the 70 ns grade (1).

A write lowers chip select and write enable on the same edge and drives the data bus for the whole overlap. The overlap ends when both strobes rise together. A recovery phase follows, so the complete write cycle meets its minimum length. A read lowers chip select and output enable and captures the byte on the last cycle of the access phase. It then holds every strobe high until the memory is guaranteed to have released the bus. While idle, chip select stays high, which keeps the memory in standby.

Back-pressure rules: `req_ready` is high only while the controller is idle, and a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The response channel has no ready. `rsp_valid` is a one-cycle pulse, and the host must take `rsp_rdata` in that cycle.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge all three strobes go high, `mem_dq_oe` goes low and `req_ready` is high.
- R2: `req_ready` is low from the cycle after a request is accepted until the `rsp_valid` cycle. A request that is held valid during an operation is carried out exactly once.
- R3: `rsp_valid` is high for exactly one cycle per request. Counted in clock edges from the accepting edge to the edge that raises `rsp_valid`, the latency is WP+WR for a write and RA+RH for a read.
- R4: A write keeps `mem_ce_n` and `mem_we_n` both low for exactly WP = max(ceil(tPWE/T), ceil(tAW/T), ceil(tSD/T)) cycles, with T = CLK_NS. The minimums are tPWE 40/50 ns, tAW 45/60 ns and tSD 25/30 ns for the fast/slow grade. The requested address and byte appear on `mem_addr` and `mem_dq_out` and stay stable throughout the overlap. Write enable is never low while chip select is high.
- R5: After the overlap, all strobes stay high for WR = max(1, ceil(tWC/T) - WP) cycles, where tWC is 55/70 ns.
- R6: A read keeps `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for RA = max(ceil(tAA/T), ceil(tDOE/T), ceil(tRC/T)) cycles. The minimums are tAA 55/70 ns, tDOE 25/35 ns and tRC 55/70 ns. The byte on `mem_dq_in` at the edge that ends the last cycle is returned on `rsp_rdata`. Output enable and write enable are never low together.
- R7: After a read, all strobes stay high for RH = ceil(tHZ/T) cycles before `rsp_valid`, where tHZ is 20/25 ns. `mem_dq_oe` is never high while `mem_oe_n` is low.
- R8: Whenever the controller is idle, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high and `mem_dq_oe` is low.
- R9: `mem_dq_oe` is high exactly in the cycles where `mem_we_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Byte address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (8) | Byte returned by the last read |
| mem_addr | output | ADDR_W (19) | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W (8) | Data toward the memory |
| mem_dq_oe | output | 1 | Enables the data drivers toward the memory |
| mem_dq_in | input | DATA_W (8) | Data from the memory |

## Verification
Some rules can be checked on every clock cycle, and the assertions cover these. Write enable never falls without chip select. Output enable and write enable are never low together. The data drivers are never on while output enable is low. The address and data stay still during an overlap. Each overlap lasts exactly WP cycles. At least RH strobe-free cycles come before the drivers turn on. The acknowledge is a one-cycle pulse, and all strobes are idle whenever the controller is ready.

Other behaviour only shows up in the bench's scenarios. These are the data actually stored and read back across a sweep of addresses, including bytes never written, and the end-to-end latencies. They also include the single execution of a request held valid for a whole operation, and the turnaround margin when a write follows a read directly.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_STROBE,
    ST_WR_RECOV,
    ST_RD_ACCESS,
    ST_RD_RELEASE
  } phase_e;

  // nanosecond minimums of one memory speed grade
  typedef struct packed {
    int unsigned cyc_wr;    // full write cycle
    int unsigned addr_wr;   // address valid before write end
    int unsigned pulse_we;  // write enable low width
    int unsigned data_su;   // data setup before write end
    int unsigned acc_addr;  // address to data valid
    int unsigned acc_oe;    // output enable to data valid
    int unsigned cyc_rd;    // full read cycle
    int unsigned rel_bus;   // memory bus release after strobe rise
  } grade_ns_t;

  function automatic grade_ns_t grade_ns(input bit slow);
    grade_ns_t g;
    if (slow) begin
      g.cyc_wr = 70; g.addr_wr = 60; g.pulse_we = 50; g.data_su = 30;
      g.acc_addr = 70; g.acc_oe = 35; g.cyc_rd = 70; g.rel_bus = 25;
    end else begin
      g.cyc_wr = 55; g.addr_wr = 45; g.pulse_we = 40; g.data_su = 25;
      g.acc_addr = 55; g.acc_oe = 25; g.cyc_rd = 55; g.rel_bus = 20;
    end
    return g;
  endfunction

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned tck);
    int unsigned c;
    c = (ns + tck - 1) / tck;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int WP    = 9,
  parameter int WR    = 2,
  parameter int RA    = 11,
  parameter int RH    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_fire,
  input  logic             req_write,
  input  logic             timer_done,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             capture,
  output logic             idle,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             rsp_valid
);
  phase_e state_q, state_d;
  logic   finish;

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    capture    = 1'b0;
    finish     = 1'b0;
    case (state_q)
      ST_IDLE: if (req_fire) begin
        timer_load = 1'b1;
        if (req_write) begin
          state_d   = ST_WR_STROBE;
          timer_val = CNT_W'(WP - 1);
        end else begin
          state_d   = ST_RD_ACCESS;
          timer_val = CNT_W'(RA - 1);
        end
      end
      ST_WR_STROBE: if (timer_done) begin
        state_d    = ST_WR_RECOV;
        timer_load = 1'b1;
        timer_val  = CNT_W'(WR - 1);
      end
      ST_WR_RECOV: if (timer_done) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      ST_RD_ACCESS: if (timer_done) begin
        state_d    = ST_RD_RELEASE;
        timer_load = 1'b1;
        timer_val  = CNT_W'(RH - 1);
        capture    = 1'b1;
      end
      ST_RD_RELEASE: if (timer_done) begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes are registered and follow the phase being entered
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      ce_n      <= !(state_d == ST_WR_STROBE || state_d == ST_RD_ACCESS);
      oe_n      <= !(state_d == ST_RD_ACCESS);
      we_n      <= !(state_d == ST_WR_STROBE);
      dq_oe     <= (state_d == ST_WR_STROBE);
      rsp_valid <= finish;
    end
  end

  assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rdata      <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 5,
  parameter bit SLOW_GRADE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam grade_ns_t G = grade_ns(SLOW_GRADE);
  localparam int WP_CYC = int'(max2(max2(ns_to_cyc(G.pulse_we, CLK_NS),
                                         ns_to_cyc(G.addr_wr, CLK_NS)),
                                    ns_to_cyc(G.data_su, CLK_NS)));
  localparam int WC_CYC = int'(ns_to_cyc(G.cyc_wr, CLK_NS));
  localparam int WR_CYC = (WC_CYC > WP_CYC) ? WC_CYC - WP_CYC : 1;
  localparam int RA_CYC = int'(max2(max2(ns_to_cyc(G.acc_addr, CLK_NS),
                                         ns_to_cyc(G.acc_oe, CLK_NS)),
                                    ns_to_cyc(G.cyc_rd, CLK_NS)));
  localparam int RH_CYC = int'(ns_to_cyc(G.rel_bus, CLK_NS));
  localparam int MAX_CYC = int'(max2(max2(WP_CYC, WR_CYC), max2(RA_CYC, RH_CYC)));
  localparam int CNT_W  = $clog2(MAX_CYC + 1);

  logic             idle, fire, capture, timer_load, timer_done;
  logic [CNT_W-1:0] timer_val;

  assign req_ready = idle;
  assign fire      = req_valid && idle;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(timer_load), .load_val(timer_val), .done(timer_done)
  );

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .WP(WP_CYC), .WR(WR_CYC), .RA(RA_CYC), .RH(RH_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_fire(fire), .req_write(req_write),
    .timer_done(timer_done), .timer_load(timer_load), .timer_val(timer_val),
    .capture(capture), .idle(idle), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
    .we_n(mem_we_n), .dq_oe(mem_dq_oe), .rsp_valid(rsp_valid)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .accept(fire), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_bus_ctrl_checks.sv
`timescale 1ns/1ps
module sram_bus_ctrl_checks #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int WP     = 9,
  parameter int RH     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);
  logic [7:0] wlow_cnt, oe_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wlow_cnt  <= '0;
      oe_hi_cnt <= 8'hFF;
    end else begin
      if (!mem_we_n) wlow_cnt <= (wlow_cnt == 8'hFF) ? wlow_cnt : wlow_cnt + 1'b1;
      else           wlow_cnt <= '0;
      if (!mem_oe_n) oe_hi_cnt <= '0;
      else           oe_hi_cnt <= (oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready));

  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_we_needs_ce_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  p_write_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  p_pulse_len_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we_n && !$past(mem_we_n)) |-> (wlow_cnt == 8'(WP)));

  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  p_no_drive_oe_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  p_release_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(RH)));

  p_idle_standby_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_drive_in_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe == !mem_we_n);
endmodule

bind sram_bus_ctrl sram_bus_ctrl_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP(WP_CYC), .RH(RH_CYC)
) u_checks (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_bus_ctrl_bench.sv
`timescale 1ns/1ps
module sram_bus_ctrl_bench;
  localparam int TCK = 5;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + TCK - 1) / TCK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // fast grade expectations, from the requirements
  localparam int E_WP = mx(mx(cdiv(40), cdiv(45)), cdiv(25));
  localparam int E_WR = mx(1, cdiv(55) - E_WP);
  localparam int E_RA = mx(mx(cdiv(55), cdiv(25)), cdiv(55));
  localparam int E_RH = cdiv(20);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'h00;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sram_bus_ctrl u_sram_bus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- memory model, evaluated away from the active edge
  logic [7:0]  bmem [0:255];
  int          rcnt = 0, wcnt = 0, hzc = 255, commits = 0;
  logic [18:0] wa, last_wa;
  logic [7:0]  wd, last_wd;
  bit          w_unstable, w_nodrive, prev_oe = 1'b0;

  initial for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'hC3;

  always @(negedge clk) begin
    if (!rst) begin
      // read access: data valid only after E_RA cycles of selection (R6)
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rcnt++;
      else rcnt = 0;
      mem_dq_in = (rcnt >= E_RA) ? bmem[mem_addr[7:0]] : ~bmem[mem_addr[7:0]];
      // bus release tracking (R7)
      if (!mem_ce_n && !mem_oe_n) hzc = 0;
      else if (hzc < 255) hzc++;
      if (mem_dq_oe && !prev_oe) chk(hzc >= E_RH + 2, "R7 release before drive", hzc, E_RH + 2);
      prev_oe = mem_dq_oe;
      // write overlap (R4, R9)
      if (!mem_ce_n && !mem_we_n) begin
        if (wcnt == 0) begin
          wa = mem_addr; wd = mem_dq_out; w_unstable = 0; w_nodrive = 0;
        end else if (mem_addr != wa || mem_dq_out != wd) w_unstable = 1;
        if (!mem_dq_oe) w_nodrive = 1;
        wcnt++;
      end else if (wcnt > 0) begin
        chk(wcnt == E_WP, "R4 overlap length", wcnt, E_WP);
        chk(!w_unstable, "R4 address/data stable", w_unstable, 0);
        chk(!w_nodrive && !mem_dq_oe, "R9 drivers follow strobe", w_nodrive, 0);
        bmem[wa[7:0]] = wd;
        last_wa = wa; last_wd = wd;
        commits++;
        wcnt = 0;
      end
    end
  end

  // ---------------- host side
  task automatic run_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        input bit hold, output logic [7:0] rd, output int lat);
    bit busy_ready;
    @(negedge clk);
    chk(req_ready, "R2 ready when idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (!hold) req_valid = 0;
    lat = 1; busy_ready = 0;
    while (!rsp_valid && lat < 300) begin
      if (req_ready) busy_ready = 1;
      @(negedge clk);
      lat++;
    end
    req_valid = 0;
    rd = rsp_rdata;
    chk(!busy_ready, "R2 ready low while busy", busy_ready, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R8 standby at ack", mem_ce_n, 1);
    @(negedge clk);
    chk(!rsp_valid, "R3 ack is one pulse", rsp_valid, 0);
  endtask

  function automatic logic [18:0] addr_of(input int i);
    return {6'(i) ^ 6'h2A, 5'd0, 8'(i)};
  endfunction
  function automatic logic [7:0] data_of(input int i);
    return 8'(i * 29 + 7);
  endfunction

  initial begin
    logic [7:0] rd;
    int lat, c0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready,
        "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
    rst = 0;

    // write sweep (R3, R4, R5, R9)
    for (int i = 0; i < 64; i++) begin
      run_op(1, addr_of(i), data_of(i), 0, rd, lat);
      chk(lat == E_WP + E_WR + 1, "R3 R5 write latency", lat, E_WP + E_WR + 1);
      chk(last_wa == addr_of(i) && last_wd == data_of(i), "R4 stored address/byte",
          int'(last_wd), int'(data_of(i)));
    end

    // read sweep over written and untouched locations (R3, R6, R7)
    for (int i = 0; i < 80; i++) begin
      logic [7:0] exp_b;
      exp_b = (i < 64) ? data_of(i) : (8'(i) ^ 8'hC3);
      run_op(0, addr_of(i), 8'h00, 0, rd, lat);
      chk(rd == exp_b, "R6 read byte", rd, exp_b);
      chk(lat == E_RA + E_RH + 1, "R3 R7 read latency", lat, E_RA + E_RH + 1);
    end

    // read directly followed by write to the same location (R7), then read back
    for (int i = 0; i < 8; i++) begin
      run_op(0, addr_of(i), 8'h00, 0, rd, lat);
      run_op(1, addr_of(i), ~data_of(i), 0, rd, lat);
      run_op(0, addr_of(i), 8'h00, 0, rd, lat);
      chk(rd == ~data_of(i), "R6 read after turnaround", rd, ~data_of(i));
    end

    // request held valid for a whole write: executed once (R2)
    c0 = commits;
    run_op(1, addr_of(200), 8'hA5, 1, rd, lat);
    repeat (3) @(negedge clk);
    chk(commits == c0 + 1, "R2 held request runs once", commits - c0, 1);
    chk(mem_ce_n && mem_we_n && req_ready, "R8 idle standby", mem_ce_n, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule